// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Token Unit

This block holds a small bank of binary token flags that two independent ports, called left and right, use to agree on who owns a shared resource. Each port has its own selects, a flag index, a write strobe, a read strobe and a data bus. A port asks for a flag by writing 0 on data bit 0 and gives it back by writing 1. If a port asks while the other side holds the flag, the request is not lost. It stays latched on the asking side and takes effect when the holder lets go.

Every flag is a small state machine with three states. `TOK_FREE` means nobody holds the flag, `TOK_LEFT` means the left port holds it and `TOK_RIGHT` means the right port holds it. The transitions are:
- claim-left: `TOK_FREE`→`TOK_LEFT`, when the left request latch goes to 0. A same-cycle tie also resolves here.
- claim-right: `TOK_FREE`→`TOK_RIGHT`, when only the right latch is 0.
- hand-over: `TOK_LEFT`↔`TOK_RIGHT`, when the holder releases while the other side's latch is 0.
- release: back to `TOK_FREE`, when the holder releases and nothing is pending.

Reads return the port's own view of a flag, repeated on every data bit. A read value is captured when a read starts and is held until the read ends.

Top module: `sema_token_unit`

## Requirements
- R1: After reset every flag is free and both ports read 8'hFF from every flag index.
- R2: The flag is chosen by address bits [2:0] only. Higher address bits have no effect on which flag is written or read.
- R3: A 0 written on data bit 0 to a free flag gives that flag to the writer. The writer then reads 8'h00 and the other port reads 8'hFF. Only the holder can change ownership.
- R4: A 0 written by the port that does not hold the flag stays pending. When the holder later writes 1, ownership passes to the pending port, which then reads 8'h00.
- R5: When the holder writes 1 and nothing is pending, the flag becomes free and both ports read 8'hFF.
- R6: Read data is always the port's view of the flag repeated on all data bits, so it is either 8'h00 or 8'hFF.
- R7: A read is active while sem_sel_n=0, ram_sel_n=1, wr_n=1 and oe_n=0. The view is captured at the first clock edge of an active read and appears on rdata after that edge. It stays frozen while the read remains active and only updates on a new read.
- R8: An access counts only when ram_sel_n=1 and sem_sel_n=0. Writes with ram_sel_n=0 or sem_sel_n=1 change nothing.
- R9: If both ports request the same free flag in the same cycle, exactly one side wins, and that side is the left port. A request that reached the flag in an earlier cycle always wins over a later one.
- R10: A write uses data bit 0 only. Bits [7:1] are ignored.
- R11: A 1 written by the port that does not hold the flag withdraws that port's pending request, so a later release frees the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| l_ram_sel_n | input | 1 | Left memory select, active low. Must be high for token access |
| l_sem_sel_n | input | 1 | Left token-space select, active low |
| l_wr_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left read strobe, active low |
| l_addr | input | ADDR_W | Left address. Bits [2:0] pick the flag |
| l_wdata | input | DATA_W | Left write data. Bit 0 is used |
| l_rdata | output | DATA_W | Left read data, held |
| r_ram_sel_n | input | 1 | Right memory select, active low |
| r_sem_sel_n | input | 1 | Right token-space select, active low |
| r_wr_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right read strobe, active low |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, held |

## Verification
The bench builds the unit with its default parameters: eight flags, a 15-bit address and an 8-bit data bus. Random upper address bits and random upper data bits test the aliasing in R2 and the ignored bits in R10. Writes from both ports land in the same cycle, and some of them are illegal double-select writes, which reaches same-cycle ties, pending hand-overs and withdrawn requests. Directed sequences add a held read across a hand-over and a left-wins tie.

// File: rtl/sema_pkg.sv
package sema_pkg;
    typedef enum logic [1:0] {
        TOK_FREE  = 2'd0,
        TOK_LEFT  = 2'd1,
        TOK_RIGHT = 2'd2
    } tok_state_e;
endpackage

// File: rtl/sema_port_dec.sv
module sema_port_dec #(
    parameter int NFLAGS = 8,
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(NFLAGS)
) (
    input  logic              ram_sel_n,
    input  logic              sem_sel_n,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NFLAGS-1:0] wr_stb,
    output logic              wr_bit,
    output logic              rd_act,
    output logic [IDX_W-1:0]  rd_idx
);
    logic legal;
    logic wr_any;

    always_comb begin
        legal  = ram_sel_n & ~sem_sel_n;
        wr_any = legal & ~wr_n;
        rd_act = legal & wr_n & ~oe_n;
        rd_idx = addr[IDX_W-1:0];
        wr_bit = wdata[0];
    end

    for (genvar g = 0; g < NFLAGS; g++) begin : g_stb
        assign wr_stb[g] = wr_any && (addr[IDX_W-1:0] == IDX_W'(g));
    end

    always_comb begin
        assert_stb_onehot_R2: assert ($onehot0(wr_stb));
    end
endmodule

// File: rtl/sema_flag_fsm.sv
module sema_flag_fsm
    import sema_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_wr,
    input  logic l_bit,
    input  logic r_wr,
    input  logic r_bit,
    output logic l_view,
    output logic r_view
);
    tok_state_e st_q, st_d;
    logic req_l_q, req_r_q;
    logic req_l_d, req_r_d;

    always_comb begin
        req_l_d = l_wr ? l_bit : req_l_q;
        req_r_d = r_wr ? r_bit : req_r_q;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TOK_FREE: begin
                if (!req_l_d)      st_d = TOK_LEFT;
                else if (!req_r_d) st_d = TOK_RIGHT;
            end
            TOK_LEFT: begin
                if (req_l_d) st_d = req_r_d ? TOK_FREE : TOK_RIGHT;
            end
            TOK_RIGHT: begin
                if (req_r_d) st_d = req_l_d ? TOK_FREE : TOK_LEFT;
            end
            default: st_d = TOK_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= TOK_FREE;
            req_l_q <= 1'b1;
            req_r_q <= 1'b1;
        end else begin
            st_q    <= st_d;
            req_l_q <= req_l_d;
            req_r_q <= req_r_d;
        end
    end

    always_comb begin
        l_view = (st_q != TOK_LEFT);
        r_view = (st_q != TOK_RIGHT);
    end

    assert_free_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TOK_FREE && l_wr && !l_bit) |=> (st_q == TOK_LEFT));
    assert_keep_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TOK_LEFT && !l_wr) |=> (st_q == TOK_LEFT));
    assert_keep_right_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TOK_RIGHT && !r_wr) |=> (st_q == TOK_RIGHT));
    assert_handoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TOK_LEFT && l_wr && l_bit && !req_r_q && !r_wr) |=> (st_q == TOK_RIGHT));
    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TOK_RIGHT && r_wr && r_bit && req_l_q && !l_wr) |=> (st_q == TOK_FREE));
    assert_tie_left_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TOK_FREE && l_wr && !l_bit && r_wr && !r_bit) |=> (!l_view && r_view));
endmodule

// File: rtl/sema_read_hold.sv
module sema_read_hold #(
    parameter int NFLAGS = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(NFLAGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_act,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [NFLAGS-1:0] views,
    output logic [DATA_W-1:0] rdata
);
    logic act_q;
    logic held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            held_q <= 1'b1;
        end else begin
            act_q <= rd_act;
            if (rd_act && !act_q) held_q <= views[rd_idx];
        end
    end

    assign rdata = {DATA_W{held_q}};

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && act_q) |=> $stable(rdata));
    assert_uniform_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata == '0) || (rdata == '1));
endmodule

// File: rtl/sema_token_unit.sv
module sema_token_unit #(
    parameter int NFLAGS = 8,
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ram_sel_n,
    input  logic              l_sem_sel_n,
    input  logic              l_wr_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_ram_sel_n,
    input  logic              r_sem_sel_n,
    input  logic              r_wr_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    localparam int IDX_W = $clog2(NFLAGS);

    logic [NFLAGS-1:0] l_stb, r_stb, l_views, r_views;
    logic              l_bit, r_bit, l_rd, r_rd;
    logic [IDX_W-1:0]  l_idx, r_idx;

    sema_port_dec #(.NFLAGS(NFLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
        .ram_sel_n(l_ram_sel_n), .sem_sel_n(l_sem_sel_n), .wr_n(l_wr_n), .oe_n(l_oe_n),
        .addr(l_addr), .wdata(l_wdata), .wr_stb(l_stb), .wr_bit(l_bit),
        .rd_act(l_rd), .rd_idx(l_idx));

    sema_port_dec #(.NFLAGS(NFLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
        .ram_sel_n(r_ram_sel_n), .sem_sel_n(r_sem_sel_n), .wr_n(r_wr_n), .oe_n(r_oe_n),
        .addr(r_addr), .wdata(r_wdata), .wr_stb(r_stb), .wr_bit(r_bit),
        .rd_act(r_rd), .rd_idx(r_idx));

    for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
        sema_flag_fsm u_flag (
            .clk(clk), .rst_n(rst_n),
            .l_wr(l_stb[g]), .l_bit(l_bit),
            .r_wr(r_stb[g]), .r_bit(r_bit),
            .l_view(l_views[g]), .r_view(r_views[g]));
    end

    sema_read_hold #(.NFLAGS(NFLAGS), .DATA_W(DATA_W)) u_hold_l (
        .clk(clk), .rst_n(rst_n), .rd_act(l_rd), .rd_idx(l_idx),
        .views(l_views), .rdata(l_rdata));

    sema_read_hold #(.NFLAGS(NFLAGS), .DATA_W(DATA_W)) u_hold_r (
        .clk(clk), .rst_n(rst_n), .rd_act(r_rd), .rd_idx(r_idx),
        .views(r_views), .rdata(r_rdata));

    assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (l_views | r_views) == '1);
    assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_ram_sel_n && !r_ram_sel_n) |=> $stable(l_views) && $stable(r_views));
endmodule

// File: tb/test_sema_token_unit.sv
module test_sema_token_unit;
    localparam int NF = 8;
    localparam int AW = 15;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_ram_sel_n, l_sem_sel_n, l_wr_n, l_oe_n;
    logic r_ram_sel_n, r_sem_sel_n, r_wr_n, r_oe_n;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int owner [NF];
    bit pend_l [NF];
    bit pend_r [NF];

    always #2.5 clk = ~clk;

    sema_token_unit #(.NFLAGS(NF), .ADDR_W(AW), .DATA_W(DW)) i_sema_token_unit (
        .clk(clk), .rst_n(rst_n),
        .l_ram_sel_n(l_ram_sel_n), .l_sem_sel_n(l_sem_sel_n), .l_wr_n(l_wr_n),
        .l_oe_n(l_oe_n), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_ram_sel_n(r_ram_sel_n), .r_sem_sel_n(r_sem_sel_n), .r_wr_n(r_wr_n),
        .r_oe_n(r_oe_n), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata));

    function automatic logic [7:0] exp_view(int own, bit left);
        if (left) return (own == 1) ? 8'h00 : 8'hFF;
        return (own == 2) ? 8'h00 : 8'hFF;
    endfunction

    function automatic logic [AW-1:0] mk_addr(int idx);
        logic [AW-1:0] a;
        a = AW'($urandom);
        a[2:0] = 3'(idx);
        return a;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        l_ram_sel_n = 1; l_sem_sel_n = 1; l_wr_n = 1; l_oe_n = 1;
        r_ram_sel_n = 1; r_sem_sel_n = 1; r_wr_n = 1; r_oe_n = 1;
    endtask

    // reference: latches update, then ownership follows the token rules
    task automatic model_step(bit lw, bit lb, int li, bit rw, bit rb, int ri);
        for (int f = 0; f < NF; f++) begin
            if (lw && li == f) pend_l[f] = lb;
            if (rw && ri == f) pend_r[f] = rb;
            case (owner[f])
                0: if (!pend_l[f]) owner[f] = 1; else if (!pend_r[f]) owner[f] = 2;
                1: if (pend_l[f]) owner[f] = pend_r[f] ? 0 : 2;
                default: if (pend_r[f]) owner[f] = pend_l[f] ? 0 : 1;
            endcase
        end
    endtask

    // one write cycle; ill_x selects an illegal double-select access
    task automatic write_cycle(bit lw, bit lb, int li, bit ill_l,
                               bit rw, bit rb, int ri, bit ill_r);
        @(negedge clk);
        idle_all();
        if (lw) begin
            l_ram_sel_n = ~ill_l; l_sem_sel_n = 0; l_wr_n = 0;
            l_addr = mk_addr(li); l_wdata = {7'($urandom), lb};
        end
        if (rw) begin
            r_ram_sel_n = ~ill_r; r_sem_sel_n = 0; r_wr_n = 0;
            r_addr = mk_addr(ri); r_wdata = {7'($urandom), rb};
        end
        @(posedge clk);
        model_step(lw && !ill_l, lb, li, rw && !ill_r, rb, ri);
        @(negedge clk);
        idle_all();
    endtask

    task automatic read_both(int idx, string req);
        @(negedge clk);
        idle_all();
        l_sem_sel_n = 0; l_oe_n = 0; l_addr = mk_addr(idx);
        r_sem_sel_n = 0; r_oe_n = 0; r_addr = mk_addr(idx);
        @(posedge clk);
        @(negedge clk);
        chk(req, l_rdata, exp_view(owner[idx], 1'b1));
        chk(req, r_rdata, exp_view(owner[idx], 1'b0));
        idle_all();
        @(posedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd24680));
        idle_all();
        l_addr = '0; r_addr = '0; l_wdata = '0; r_wdata = '0;
        for (int f = 0; f < NF; f++) begin owner[f] = 0; pend_l[f] = 1; pend_r[f] = 1; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: every flag free after reset
        for (int f = 0; f < NF; f++) read_both(f, "R1 reset free");

        // R3 claim by right, R4 pending left, hand-over on release
        write_cycle(0, 0, 0, 0, 1, 0, 2, 0);
        read_both(2, "R3 right claims");
        write_cycle(1, 0, 2, 0, 0, 0, 0, 0);
        read_both(2, "R3 non-owner cannot take");
        write_cycle(0, 0, 0, 0, 1, 1, 2, 0);
        read_both(2, "R4 pending hand-over");
        write_cycle(1, 1, 2, 0, 0, 0, 0, 0);
        read_both(2, "R5 release to free");

        // R9 tie goes left; R11 withdrawn request
        write_cycle(1, 0, 5, 0, 1, 0, 5, 0);
        read_both(5, "R9 tie left wins");
        write_cycle(0, 0, 0, 0, 1, 1, 5, 0);
        write_cycle(1, 1, 5, 0, 0, 0, 0, 0);
        read_both(5, "R11 withdraw then free");

        // R8 illegal access ignored
        write_cycle(1, 0, 1, 1, 1, 0, 1, 1);
        read_both(1, "R8 illegal write ignored");

        // R7 held read across a hand-over
        write_cycle(1, 0, 3, 0, 0, 0, 0, 0);
        write_cycle(0, 0, 0, 0, 1, 0, 3, 0);
        @(negedge clk);
        r_sem_sel_n = 0; r_oe_n = 0; r_addr = mk_addr(3);
        @(posedge clk);
        @(negedge clk);
        chk("R7 captured view", r_rdata, 8'hFF);
        l_sem_sel_n = 0; l_wr_n = 0; l_addr = mk_addr(3); l_wdata = 8'hFF;
        @(posedge clk);
        model_step(1, 1, 3, 0, 0, 0);
        @(negedge clk);
        l_sem_sel_n = 1; l_wr_n = 1;
        @(posedge clk);
        @(negedge clk);
        chk("R7 frozen while active", r_rdata, 8'hFF);
        idle_all();
        @(posedge clk);
        read_both(3, "R7 update after toggle");

        // random mix: R2 aliasing, R6 replication, R10 ignored bits
        for (int i = 0; i < 400; i++) begin
            int li, ri;
            li = int'($urandom_range(NF - 1));
            ri = ($urandom_range(3) == 0) ? li : int'($urandom_range(NF - 1));
            write_cycle(1'($urandom), 1'($urandom), li, ($urandom_range(7) == 0),
                        1'($urandom), 1'($urandom), ri, ($urandom_range(7) == 0));
            read_both(($urandom_range(1) == 0) ? li : ri, "R2 R6 R10 random");
        end
        finish_run();
    end
endmodule